// File: doc/BRIEF.md
# Bus Transfer Latency Counter

This block passively watches the read-address channel of a shared memory interconnect and times one DMA transfer. The interconnect presents one ARVALID bit and one ARREADY bit per master. The block uses only the bit of one chosen master. A cycle counter starts on that master's first accepted read address. It stops when the DMA engine raises its completion interrupt.

Software drives the block through a small AXI4-Lite slave. It clears the block, arms it, waits for the done flag and reads the elapsed cycle count. From that count it works out throughput. The counter runs on the interconnect clock. The register slave runs on a separate peripheral clock that may be asynchronous to it. Commands are carried into the counter domain as synchronised toggles. Status is carried back through flop chains, and the final count sits in a holding register that is frozen before the done flag reaches software.

Top module: `xfer_latency_mon`

## Requirements
- R1: After reset, every readable register returns 0, the state machine is idle, and neither bvalid nor rvalid is asserted.
- R2: An armed monitor starts counting only in a counter-clock cycle where bit MSTID of both `mon_arvalid_i` and `mon_arready_i` is high. A handshake on any other bit, or ARVALID without ARREADY, has no effect.
- R3: While counting, the interrupt input is sampled as a level on each counter-clock edge. The handshake cycle counts as 1. When the interrupt is sampled high k cycles after the handshake cycle, the captured count is k, done is set and the monitor returns to idle.
- R4: The count saturates at 2^CNT_W-1 and never wraps. A cycle that would pass the maximum sets the sticky overflow flag, status bit 2.
- R5: The count register at offset 0x8 returns the captured value, zero-extended to 32 bits. That value does not change while done is set.
- R6: The interrupt has no effect while the monitor is idle or armed. Further handshakes while counting do not restart the count.
- R7: Writing 1 to control bit 0 (arm) at offset 0x0 is accepted only when the monitor is idle and done is clear. Otherwise the write is ignored.
- R8: Writing 1 to control bit 1 (clear) zeroes the count, done and overflow and returns the monitor to idle from any state. When arm and clear are written together, only the clear takes effect.
- R9: Status at offset 0x4 holds bit 0 busy (armed or counting), bit 1 done and bit 2 overflow. The control register reads as 0, and any other offset reads as 0.
- R10: Every write response and read response is OKAY (0). Each channel holds one transaction at a time, and bvalid and rvalid stay high until accepted.
- R11: Commands and status cross between the two clock domains. A status read taken some time after an arm shows busy even though the two clocks are unrelated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Interconnect (counter) clock |
| pclk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset for both domains |
| mon_arvalid_i | input | MSTID_WIDTH | Snooped per-master ARVALID vector |
| mon_arready_i | input | MSTID_WIDTH | Snooped per-master ARREADY vector |
| dma_irq_i | input | 1 | DMA completion interrupt, level |
| s_awaddr_i | input | ADDR_W | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | ADDR_W | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |

## Verification
The bench builds the block with a 4-bit master vector, the monitored master at bit 2 and an 8-bit counter. It uses a 10 ns counter clock and a 14 ns register clock. The narrow counter brings saturation within a few hundred cycles. The bench therefore sweeps the interrupt delay through short values and through the 255 boundary, and predicts min(k,255) and the overflow flag arithmetically. The 4-bit vector lets every non-monitored bit be tried as a false trigger.

// File: rtl/lat_mon_pkg.sv
package lat_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'b00,
    ST_ARMED    = 2'b01,
    ST_COUNTING = 2'b11
  } mon_state_e;

  localparam logic [31:0] OFF_CTRL   = 32'h0;
  localparam logic [31:0] OFF_STATUS = 32'h4;
  localparam logic [31:0] OFF_COUNT  = 32'h8;

  localparam int CTRL_ARM_BIT = 0;
  localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/lat_mon_pulse_sync.sv
module lat_mon_pulse_sync #(
  parameter int STAGES = 2
) (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic src_pulse_i,
  output logic dst_pulse_o
);
  logic            src_tgl;
  logic [STAGES:0] dst_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni)          src_tgl <= 1'b0;
    else if (src_pulse_i) src_tgl <= ~src_tgl;
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) dst_q <= '0;
    else         dst_q <= {dst_q[STAGES-1:0], src_tgl};
  end

  assign dst_pulse_o = dst_q[STAGES] ^ dst_q[STAGES-1];
endmodule

// File: rtl/lat_mon_bit_sync.sv
module lat_mon_bit_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/lat_mon_core.sv
module lat_mon_core
  import lat_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hs_i,
  input  logic             irq_i,
  input  logic             arm_i,
  input  logic             clr_i,
  output mon_state_e       state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] hold_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  mon_state_e       state_q;
  logic [CNT_W-1:0] cnt_q, hold_q;
  logic             done_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (clr_i) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      hold_q  <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (arm_i && !done_q) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
            ovf_q   <= 1'b0;
          end
        end
        ST_ARMED: begin
          if (hs_i) begin
            state_q <= ST_COUNTING;
            cnt_q   <= CNT_W'(1);
          end
        end
        ST_COUNTING: begin
          if (irq_i) begin
            hold_q  <= cnt_q;   // frozen before done leaves this domain
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (cnt_q == CNT_MAX) begin
            ovf_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign cnt_o   = cnt_q;
  assign hold_o  = hold_q;
  assign busy_o  = state_q[0];  // single flop bit: glitch-free for CDC
  assign done_o  = done_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/lat_mon_regs.sv
module lat_mon_regs
  import lat_mon_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 32
) (
  input  logic              pclk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [31:0]       wdata_i,
  input  logic [3:0]        wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [ADDR_W-1:0] araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [31:0]       rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic              ovf_i,
  input  logic [CNT_W-1:0]  hold_i,
  output logic              arm_o,
  output logic              clr_o
);
  logic        bvalid_q, rvalid_q;
  logic [31:0] rdata_q, rd_mux;
  logic        wr_fire, rd_fire, ctl_hit;
  logic        unused_w;

  assign wr_fire   = awvalid_i & wvalid_i & ~bvalid_q;
  assign awready_o = wr_fire;
  assign wready_o  = wr_fire;
  assign ctl_hit   = wr_fire && (awaddr_i == ADDR_W'(OFF_CTRL)) && wstrb_i[0];
  assign clr_o     = ctl_hit & wdata_i[CTRL_CLR_BIT];
  assign arm_o     = ctl_hit & wdata_i[CTRL_ARM_BIT] & ~wdata_i[CTRL_CLR_BIT];
  assign unused_w  = ^{wdata_i[31:2], wstrb_i[3:1]};

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni)       bvalid_q <= 1'b0;
    else if (wr_fire)  bvalid_q <= 1'b1;
    else if (bready_i) bvalid_q <= 1'b0;
  end

  assign rd_fire   = arvalid_i & ~rvalid_q;
  assign arready_o = ~rvalid_q;

  always_comb begin
    rd_mux = '0;
    if (araddr_i == ADDR_W'(OFF_STATUS))     rd_mux = {29'd0, ovf_i, done_i, busy_i};
    else if (araddr_i == ADDR_W'(OFF_COUNT)) rd_mux = 32'(hold_i);
  end

  always_ff @(posedge pclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_mux;
    end else if (rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign bvalid_o = bvalid_q;
  assign bresp_o  = 2'b00;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign rresp_o  = 2'b00;
endmodule

// File: rtl/xfer_latency_mon.sv
module xfer_latency_mon
  import lat_mon_pkg::*;
#(
  parameter int MSTID_WIDTH = 4,
  parameter int MSTID       = 0,
  parameter int CNT_W       = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   pclk_i,
  input  logic                   rst_ni,
  input  logic [MSTID_WIDTH-1:0] mon_arvalid_i,
  input  logic [MSTID_WIDTH-1:0] mon_arready_i,
  input  logic                   dma_irq_i,
  input  logic [ADDR_W-1:0]      s_awaddr_i,
  input  logic                   s_awvalid_i,
  output logic                   s_awready_o,
  input  logic [31:0]            s_wdata_i,
  input  logic [3:0]             s_wstrb_i,
  input  logic                   s_wvalid_i,
  output logic                   s_wready_o,
  output logic [1:0]             s_bresp_o,
  output logic                   s_bvalid_o,
  input  logic                   s_bready_i,
  input  logic [ADDR_W-1:0]      s_araddr_i,
  input  logic                   s_arvalid_i,
  output logic                   s_arready_o,
  output logic [31:0]            s_rdata_o,
  output logic [1:0]             s_rresp_o,
  output logic                   s_rvalid_o,
  input  logic                   s_rready_i
);
  logic             mon_hs, unused_vec;
  logic             arm_p, clr_p, arm_c, clr_c;
  mon_state_e       core_state;
  logic [CNT_W-1:0] core_cnt, cnt_hold;
  logic             busy_c, done_c, ovf_c;
  logic [2:0]       stat_p;

  assign mon_hs     = mon_arvalid_i[MSTID] & mon_arready_i[MSTID];
  assign unused_vec = ^{mon_arvalid_i, mon_arready_i};

  lat_mon_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .pclk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .busy_i(stat_p[0]), .done_i(stat_p[1]), .ovf_i(stat_p[2]), .hold_i(cnt_hold),
    .arm_o(arm_p), .clr_o(clr_p)
  );

  lat_mon_pulse_sync #(.STAGES(SYNC_STAGES)) u_arm_sync (
    .src_clk_i(pclk_i), .dst_clk_i(clk_i), .rst_ni, .src_pulse_i(arm_p), .dst_pulse_o(arm_c)
  );

  lat_mon_pulse_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
    .src_clk_i(pclk_i), .dst_clk_i(clk_i), .rst_ni, .src_pulse_i(clr_p), .dst_pulse_o(clr_c)
  );

  lat_mon_core #(.CNT_W(CNT_W)) u_core (
    .clk_i, .rst_ni, .hs_i(mon_hs), .irq_i(dma_irq_i), .arm_i(arm_c), .clr_i(clr_c),
    .state_o(core_state), .cnt_o(core_cnt), .hold_o(cnt_hold),
    .busy_o(busy_c), .done_o(done_c), .ovf_o(ovf_c)
  );

  lat_mon_bit_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_stat_sync (
    .clk_i(pclk_i), .rst_ni, .d_i({ovf_c, done_c, busy_c}), .q_o(stat_p)
  );
endmodule

// File: rtl/lat_mon_chk.sv
module lat_mon_chk
  import lat_mon_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             pclk_i,
  input logic             rst_ni,
  input logic             hs_i,
  input logic             irq_i,
  input logic             clr_i,
  input mon_state_e       state_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] hold_i,
  input logic             done_i,
  input logic             ovf_i,
  input logic             bvalid_i,
  input logic             bready_i,
  input logic             rvalid_i,
  input logic             rready_i
);
  a_r2_start_needs_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_COUNTING) && ($past(state_i) != ST_COUNTING) |-> $past(hs_i));

  a_r3_stop_on_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_COUNTING) && irq_i && !clr_i |=> done_i && (state_i == ST_IDLE));

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_COUNTING) && !irq_i && !clr_i |=>
      (cnt_i == CNT_W'($past(cnt_i) + 1'b1)) || ((cnt_i == $past(cnt_i)) && ovf_i));

  a_r5_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i && !clr_i |=> $stable(hold_i));

  a_r7_no_rearm_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) && done_i && !clr_i |=> (state_i == ST_IDLE));

  a_r8_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (state_i == ST_IDLE) && !done_i && !ovf_i && (cnt_i == '0) && (hold_i == '0));

  a_r10_bvalid_hold: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    bvalid_i && !bready_i |=> bvalid_i);

  a_r10_rvalid_hold: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    rvalid_i && !rready_i |=> rvalid_i);
endmodule

bind xfer_latency_mon lat_mon_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .pclk_i(pclk_i), .rst_ni(rst_ni),
  .hs_i(mon_hs), .irq_i(dma_irq_i), .clr_i(clr_c),
  .state_i(core_state), .cnt_i(core_cnt), .hold_i(cnt_hold),
  .done_i(done_c), .ovf_i(ovf_c),
  .bvalid_i(s_bvalid_o), .bready_i(s_bready_i),
  .rvalid_i(s_rvalid_o), .rready_i(s_rready_i)
);

// File: tb/tb_xfer_latency_mon.sv
module tb_xfer_latency_mon;
  localparam int CLK_PERIOD  = 10;
  localparam int PCLK_PERIOD = 14;
  localparam int NM    = 4;
  localparam int MID   = 2;
  localparam int CW    = 8;
  localparam int AW    = 4;
  localparam int CMAX  = (1 << CW) - 1;

  logic clk = 0, pclk = 0, rst_n = 0;
  logic [NM-1:0] arv = '0, arr = '0;
  logic irq = 0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, arvalid = 0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(PCLK_PERIOD/2) pclk = ~pclk;

  xfer_latency_mon #(.MSTID_WIDTH(NM), .MSTID(MID), .CNT_W(CW), .ADDR_W(AW)) dut (
    .clk_i(clk), .pclk_i(pclk), .rst_ni(rst_n),
    .mon_arvalid_i(arv), .mon_arready_i(arr), .dma_irq_i(irq),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(1'b1),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(1'b1)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic axi_wr(logic [AW-1:0] a, logic [31:0] d, output logic [1:0] resp);
    @(negedge pclk);
    awaddr = a; wdata = d; wstrb = 4'hF; awvalid = 1; wvalid = 1;
    @(posedge pclk);
    @(negedge pclk);
    awvalid = 0; wvalid = 0;
    resp = bvalid ? bresp : 2'b11;
  endtask

  task automatic axi_rd(logic [AW-1:0] a, output logic [31:0] d, output logic [1:0] resp);
    @(negedge pclk);
    araddr = a; arvalid = 1;
    @(posedge pclk);
    @(negedge pclk);
    arvalid = 0;
    d = rvalid ? rdata : 32'hDEAD_BEEF;
    resp = rvalid ? rresp : 2'b11;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    logic [1:0] r;
    axi_wr(a, d, r);
    repeat (8) @(negedge clk);
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    logic [1:0] r;
    axi_rd(a, d, r);
  endtask

  task automatic wait_done(output logic [31:0] st);
    st = 0;
    for (int i = 0; i < 40; i++) begin
      rd(4'h4, st);
      if (st[1]) break;
    end
  endtask

  // handshake at one edge, then irq sampled k edges later; optional repeat handshake
  task automatic run_xfer(int k, bit dup);
    @(negedge clk); arv[MID] = 1; arr[MID] = 1;
    @(negedge clk); arv = '0; arr = '0;
    for (int i = 1; i < k; i++) begin
      @(negedge clk);
      if (dup && i == 2) begin arv[MID] = 1; arr[MID] = 1; end
      else begin arv = '0; arr = '0; end
    end
    irq = 1; arv = '0; arr = '0;
    @(negedge clk); irq = 0;
  endtask

  task automatic measure(int k, bit dup, string req);
    logic [31:0] st, c1, c2;
    int exp_c;
    wr(4'h0, 32'h2);
    wr(4'h0, 32'h1);
    run_xfer(k, dup);
    wait_done(st);
    exp_c = (k > CMAX) ? CMAX : k;
    check({req, " status"}, st, (k > CMAX) ? 32'h6 : 32'h2);
    rd(4'h8, c1);
    rd(4'h8, c2);
    check({req, " count"}, c1, exp_c);
    check("R5 count stable", c2, c1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [1:0] rs;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge pclk);

    // R1 / R9: reset state and map
    check("R1 bvalid idle", {31'd0, bvalid}, 0);
    check("R1 rvalid idle", {31'd0, rvalid}, 0);
    for (int a = 0; a < 16; a += 4) begin
      axi_rd(AW'(a), d, rs);
      check("R1 reset read", d, 0);
      check("R10 rresp", {30'd0, rs}, 0);
    end
    axi_wr(4'h0, 32'h0, rs);
    check("R10 bresp", {30'd0, rs}, 0);

    // R3 / R4: sweep of interrupt delay, including saturation boundary
    for (int k = 1; k <= 10; k++) measure(k, 0, "R3");
    for (int k = CMAX - 3; k <= CMAX + 4; k++) measure(k, 0, "R4");

    // R2 / R6 / R11: false triggers while armed
    wr(4'h0, 32'h2);
    wr(4'h0, 32'h1);
    rd(4'h4, d);
    check("R11 busy after arm", d, 32'h1);
    for (int b = 0; b < NM; b++) begin
      if (b == MID) continue;
      @(negedge clk); arv[b] = 1; arr[b] = 1;
      @(negedge clk); arv = '0; arr = '0;
    end
    @(negedge clk); arv[MID] = 1;
    @(negedge clk); arv = '0;
    @(negedge clk); arr[MID] = 1;
    @(negedge clk); arr = '0;
    @(negedge clk); irq = 1;
    repeat (3) @(negedge clk); irq = 0;
    repeat (4) @(negedge clk);
    rd(4'h4, d);
    check("R2 R6 still armed", d, 32'h1);
    run_xfer(5, 0);
    wait_done(d);
    rd(4'h8, d);
    check("R2 count after false triggers", d, 5);

    // R6: repeat handshake while counting
    measure(7, 1, "R6");

    // R7: arm while done is ignored
    wr(4'h0, 32'h1);
    run_xfer(3, 0);
    rd(4'h4, d);
    check("R7 status unchanged", d, 32'h2);
    rd(4'h8, d);
    check("R7 count unchanged", d, 7);

    // R8: clear while counting
    wr(4'h0, 32'h2);
    wr(4'h0, 32'h1);
    @(negedge clk); arv[MID] = 1; arr[MID] = 1;
    @(negedge clk); arv = '0; arr = '0;
    wr(4'h0, 32'h2);
    @(negedge clk); irq = 1;
    @(negedge clk); irq = 0;
    repeat (4) @(negedge clk);
    rd(4'h4, d);
    check("R8 status after clear", d, 0);
    rd(4'h8, d);
    check("R8 count after clear", d, 0);

    // R8: arm and clear together -> clear only
    wr(4'h0, 32'h3);
    rd(4'h4, d);
    check("R8 arm+clear not busy", d, 0);
    rd(4'h0, d);
    check("R9 ctrl reads zero", d, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule